// File: doc/BRIEF.md
# YCbCr 4:2:2 Input Demultiplexer

This block takes 4:2:2 YCbCr pixel data on one of three input packings and turns it into aligned 4:4:4 samples. Each sample is a luma value with its Cb and Cr, marked by a one-cycle valid strobe. The three packings are a parallel one, a byte-multiplexed one, and a byte-multiplexed one with embedded timing references. In the parallel packing, luma and the chroma stream travel on separate byte lanes. In the two byte-wide packings, everything shares the low lane. The block runs on a clock at twice the pixel rate. A pixel-phase input gives the level of the pixel-rate clock.

In the embedded packing, the block finds timing reference words, which are a three-byte preamble followed by a flag byte. It reports start-of-active and end-of-active strobes together with the field and vertical-blank flags. It takes pixels only inside an active window that opens on a start code outside vertical blanking. Ancillary and blanking bytes between windows are dropped.

Chroma reaches 4:4:4 by repetition: each Cb/Cr pair is given to both luma samples of its group. Luma below the black floor of 16 is raised to 16. Luma above 235 is not touched. Chroma is never altered.

Top module: `ycc_ingest`

## Requirements
- R1: With `fmt_sel`=0 (parallel), luma comes from `din[15:8]` and the chroma stream from `din[7:0]`. The first chroma of each group is Cb and the second is Cr.
- R2: With `fmt_sel`=0, inputs are taken only on edges where `pix_ph`=0. Bus and `act_in` values during `pix_ph`=1 cycles have no effect on the output.
- R3: With `fmt_sel`=1 (byte-multiplexed), one byte is taken from `din[7:0]` on every edge while `act_in`=1, in the order Cb, Y, Cr, Y. `din[15:8]` is ignored.
- R4: In modes 0 and 1, a taken sample with `act_in`=0 restarts the order at Cb. A group that is not yet complete is discarded.
- R5: A finished group produces exactly two pixels on consecutive cycles, both carrying the group's Cb and Cr. The first pixel appears one cycle after the group's last sample. `pix_vld` is high for one cycle per luma sample.
- R6: A luma below 16 leaves as 16. Luma values from 16 to 255 leave unchanged.
- R7: Cb and Cr leave unchanged for every value from 0 to 255.
- R8: With `fmt_sel`=2 (embedded), the byte sequence FF, 00, 00, XY is a timing reference. XY bit 4 = 1 marks end-of-active and 0 marks start-of-active. Bit 6 is the field and bit 5 is vertical blank. One cycle after XY is taken, `eav_stb` or `sav_stb` pulses for one cycle, and `field_o` and `vblank_o` take the flag values and hold them.
- R9: With `fmt_sel`=2, pixels are taken only after a start code with bit 5 = 0 and before the next FF byte. Bytes after an end code, bytes after a start code with bit 5 = 1, a partial group cut off by a reference, and `act_in` all have no effect.
- R10: With `fmt_sel`=2, every start code restarts the byte order at Cb.
- R11: After reset, all outputs are 0.
- R12: In modes 0 and 1, `sav_stb` and `eav_stb` stay 0, and a byte of value FF is ordinary pixel data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Packing: 0 parallel, 1 byte-multiplexed, 2 embedded timing, 3 treated as 1 |
| pix_ph | input | 1 | Pixel-rate clock level; parallel packing samples when 0 |
| act_in | input | 1 | Active-data qualifier for packings 0 and 1 |
| din | input | 16 | Input bus; high lane luma (parallel), low lane chroma or shared bytes |
| y_o | output | 8 | Luma of the current 4:4:4 pixel, floor-clamped |
| cb_o | output | 8 | Cb of the current pixel |
| cr_o | output | 8 | Cr of the current pixel |
| pix_vld | output | 1 | One-cycle strobe per output pixel |
| sav_stb | output | 1 | Start-of-active reference seen |
| eav_stb | output | 1 | End-of-active reference seen |
| field_o | output | 1 | Field flag from the last reference |
| vblank_o | output | 1 | Vertical-blank flag from the last reference |

## Verification
The bench puts garbage on the bus during the unsampled half of each parallel pixel. A design that ignored `pix_ph` would emit extra or mixed pixels. It feeds luma of 5, 15, 235 and 255 and extreme chroma values. A wrong clamp would lift 235 to the floor, cap 255, or touch chroma. Partial groups are cut by `act_in` and by an embedded reference. A design that failed to restart at Cb would pair the wrong bytes, and this shows as a popped pixel with swapped Cb/Cr or luma. Ancillary bytes and a vertical-blank start code are sent with `act_in` toggling at random. A window that opened on those would push unexpected pixels into the scoreboard.

// File: rtl/ycc_pkg.sv
// Package: shared encodings for the YCbCr input demultiplexer.
// Assumes: two-bit format select; preamble matcher needs four states.
package ycc_pkg;

    typedef enum logic [1:0] {
        FMT_WIDE   = 2'd0,
        FMT_NARROW = 2'd1,
        FMT_EMB    = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        PRE_SEEK = 2'd0,
        PRE_ONES = 2'd1,
        PRE_Z1   = 2'd2,
        PRE_Z2   = 2'd3
    } pre_e;

endpackage

// File: rtl/ycc_trs_parser.sv
// Module: finds embedded timing references (all-ones, zero, zero, flag word)
// on the shared byte lane and keeps the active-video window.
// Assumes: en is high on every sampled byte of the embedded packing; pixel
// bytes never take the all-ones value, so that value always starts a reference.
module ycc_trs_parser
    import ycc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] byte_i,
    output logic         acc_o,
    output logic         sav_stb_o,
    output logic         eav_stb_o,
    output logic         field_o,
    output logic         vblank_o
);

    localparam int H_BIT = W - 4;
    localparam int V_BIT = W - 3;
    localparam int F_BIT = W - 2;

    pre_e pre_q;
    logic win_q;
    logic is_ones;
    logic is_zero;
    logic flag_now;

    assign is_ones  = &byte_i;
    assign is_zero  = ~|byte_i;
    assign flag_now = en && (pre_q == PRE_Z2);
    assign acc_o    = en && win_q && !is_ones;

    // Advance the preamble matcher by one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_SEEK;
        end else if (en) begin
            case (pre_q)
                PRE_SEEK: pre_q <= is_ones ? PRE_ONES : PRE_SEEK;
                PRE_ONES: pre_q <= is_zero ? PRE_Z1 : (is_ones ? PRE_ONES : PRE_SEEK);
                PRE_Z1:   pre_q <= is_zero ? PRE_Z2 : (is_ones ? PRE_ONES : PRE_SEEK);
                default:  pre_q <= PRE_SEEK;
            endcase
        end
    end

    // Open the window on a start code outside blanking, close it on any reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (flag_now) begin
            win_q <= !byte_i[H_BIT] && !byte_i[V_BIT];
        end else if (en && is_ones) begin
            win_q <= 1'b0;
        end
    end

    // Register strobes and hold the decoded flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_stb_o <= 1'b0;
            eav_stb_o <= 1'b0;
            field_o   <= 1'b0;
            vblank_o  <= 1'b0;
        end else begin
            sav_stb_o <= flag_now && !byte_i[H_BIT];
            eav_stb_o <= flag_now &&  byte_i[H_BIT];
            if (flag_now) begin
                field_o  <= byte_i[F_BIT];
                vblank_o <= byte_i[V_BIT];
            end
        end
    end

    AST_EAV_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        eav_stb_o |-> !win_q); // R9

endmodule

// File: rtl/ycc_group_asm.sv
// Module: collects one 4:2:2 group (Cb, Y0, Cr, Y1) from either the parallel
// lanes (two samples) or the shared byte lane (four samples).
// Assumes: en marks sampled edges; acc low on a sampled edge restarts at Cb.
module ycc_group_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         acc,
    input  logic         wide,
    input  logic [W-1:0] luma_i,
    input  logic [W-1:0] chroma_i,
    output logic         done_o,
    output logic [W-1:0] y0_o,
    output logic [W-1:0] y1_o,
    output logic [W-1:0] cb_o,
    output logic [W-1:0] cr_o
);

    localparam int SLOTS = 4;
    localparam int IW    = $clog2(SLOTS);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_slot;
    logic [W-1:0]  cb_q;
    logic [W-1:0]  y0_q;
    logic [W-1:0]  cr_q;

    assign last_slot = wide ? IW'(1) : IW'(SLOTS - 1);
    assign done_o    = en && acc && (idx_q == last_slot);
    assign y0_o      = y0_q;
    assign y1_o      = luma_i;
    assign cb_o      = cb_q;
    assign cr_o      = wide ? chroma_i : cr_q;

    // Step the slot index and latch each slot's sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cb_q  <= '0;
            y0_q  <= '0;
            cr_q  <= '0;
        end else if (en) begin
            if (!acc) begin
                idx_q <= '0;
            end else if (wide) begin
                if (idx_q == '0) begin
                    cb_q  <= chroma_i;
                    y0_q  <= luma_i;
                    idx_q <= IW'(1);
                end else begin
                    idx_q <= '0;
                end
            end else begin
                case (idx_q)
                    IW'(0):  cb_q <= chroma_i;
                    IW'(1):  y0_q <= luma_i;
                    IW'(2):  cr_q <= chroma_i;
                    default: ;
                endcase
                idx_q <= idx_q + IW'(1);
            end
        end
    end

endmodule

// File: rtl/ycc_pixel_out.sv
// Module: turns a finished group into two 4:4:4 pixels on consecutive cycles,
// repeating the chroma pair and raising luma to the black floor.
// Assumes: groups finish at least three cycles apart.
module ycc_pixel_out #(
    parameter int W      = 8,
    parameter int YFLOOR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done_i,
    input  logic [W-1:0] y0_i,
    input  logic [W-1:0] y1_i,
    input  logic [W-1:0] cb_i,
    input  logic [W-1:0] cr_i,
    output logic [W-1:0] y_o,
    output logic [W-1:0] cb_o,
    output logic [W-1:0] cr_o,
    output logic         vld_o
);

    localparam logic [W-1:0] FLOOR = W'(YFLOOR);

    logic         pend_q;
    logic [W-1:0] y1_q;

    function automatic logic [W-1:0] lift(input logic [W-1:0] v);
        return (v < FLOOR) ? FLOOR : v;
    endfunction

    // Emit the first pixel of a group, then the held second one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o    <= '0;
            cb_o   <= '0;
            cr_o   <= '0;
            vld_o  <= 1'b0;
            pend_q <= 1'b0;
            y1_q   <= '0;
        end else if (done_i) begin
            y_o    <= lift(y0_i);
            cb_o   <= cb_i;
            cr_o   <= cr_i;
            y1_q   <= lift(y1_i);
            vld_o  <= 1'b1;
            pend_q <= 1'b1;
        end else if (pend_q) begin
            y_o    <= y1_q;
            vld_o  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            vld_o  <= 1'b0;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !pend_q); // R5
    AST_LUMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (y_o >= FLOOR)); // R6

endmodule

// File: rtl/ycc_ingest.sv
// Module: top of the YCbCr input demultiplexer. Selects the packing, gates
// sampling by pixel phase, and joins the reference parser, group assembler
// and pixel emitter.
// Assumes: fmt_sel changes only while no video flows.
module ycc_ingest
    import ycc_pkg::*;
#(
    parameter int W      = 8,
    parameter int YFLOOR = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     fmt_sel,
    input  logic           pix_ph,
    input  logic           act_in,
    input  logic [2*W-1:0] din,
    output logic [W-1:0]   y_o,
    output logic [W-1:0]   cb_o,
    output logic [W-1:0]   cr_o,
    output logic           pix_vld,
    output logic           sav_stb,
    output logic           eav_stb,
    output logic           field_o,
    output logic           vblank_o
);

    fmt_e         fmt;
    logic         wide;
    logic         emb;
    logic         smp_en;
    logic         emb_acc;
    logic         acc;
    logic [W-1:0] lo_lane;
    logic [W-1:0] luma_in;
    logic         grp_done;
    logic [W-1:0] g_y0;
    logic [W-1:0] g_y1;
    logic [W-1:0] g_cb;
    logic [W-1:0] g_cr;

    // Decode the packing and pick lanes and sample qualifier.
    always_comb begin
        fmt     = fmt_e'(fmt_sel);
        wide    = (fmt == FMT_WIDE);
        emb     = (fmt == FMT_EMB);
        smp_en  = wide ? !pix_ph : 1'b1;
        lo_lane = din[W-1:0];
        luma_in = wide ? din[2*W-1:W] : lo_lane;
        acc     = emb ? emb_acc : act_in;
    end

    ycc_trs_parser #(.W(W)) u_trs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (emb),
        .byte_i    (lo_lane),
        .acc_o     (emb_acc),
        .sav_stb_o (sav_stb),
        .eav_stb_o (eav_stb),
        .field_o   (field_o),
        .vblank_o  (vblank_o)
    );

    ycc_group_asm #(.W(W)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (smp_en),
        .acc      (acc),
        .wide     (wide),
        .luma_i   (luma_in),
        .chroma_i (lo_lane),
        .done_o   (grp_done),
        .y0_o     (g_y0),
        .y1_o     (g_y1),
        .cb_o     (g_cb),
        .cr_o     (g_cr)
    );

    ycc_pixel_out #(.W(W), .YFLOOR(YFLOOR)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (grp_done),
        .y0_i   (g_y0),
        .y1_i   (g_y1),
        .cb_i   (g_cb),
        .cr_i   (g_cr),
        .y_o    (y_o),
        .cb_o   (cb_o),
        .cr_o   (cr_o),
        .vld_o  (pix_vld)
    );

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_vld) |=> pix_vld && $stable(cb_o) && $stable(cr_o)); // R5
    AST_WIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == FMT_WIDE) && pix_ph |-> !grp_done); // R2
    AST_STB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel != FMT_EMB) && $past(fmt_sel != FMT_EMB) |-> !sav_stb && !eav_stb); // R12

endmodule

// File: tb/ycc_ingest_bench.sv
module ycc_ingest_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        pix_ph = 1'b0;
    logic        act_in = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  y_o, cb_o, cr_o;
    logic        pix_vld, sav_stb, eav_stb, field_o, vblank_o;

    int nchk  = 0;
    int nfail = 0;
    int stray = 0;
    logic [23:0] exp_q[$];

    always #5 clk = ~clk;

    ycc_ingest u_ycc_ingest (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pix_ph(pix_ph),
        .act_in(act_in), .din(din), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o),
        .pix_vld(pix_vld), .sav_stb(sav_stb), .eav_stb(eav_stb),
        .field_o(field_o), .vblank_o(vblank_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] floor16(input logic [7:0] v);
        return (v < 8'd16) ? 8'd16 : v;
    endfunction

    // Push the two pixels a complete group must yield (R5 R6 R7).
    task automatic expect_grp(input logic [7:0] cb, input logic [7:0] y0,
                              input logic [7:0] cr, input logic [7:0] y1);
        exp_q.push_back({floor16(y0), cb, cr});
        exp_q.push_back({floor16(y1), cb, cr});
    endtask

    // Parallel sample: taken half, then a junk half with pix_ph high (R1 R2).
    task automatic ws(input logic [7:0] y, input logic [7:0] c, input logic a);
        pix_ph = 1'b0; din = {y, c}; act_in = a;
        @(negedge clk);
        pix_ph = 1'b1; din = 16'($urandom); act_in = 1'($urandom);
        @(negedge clk);
    endtask

    // Shared-lane byte with junk on the upper lane (R3).
    task automatic nb(input logic [7:0] b, input logic a);
        din = {8'($urandom), b}; act_in = a; pix_ph = ~pix_ph;
        @(negedge clk);
    endtask

    task automatic trs(input logic [7:0] xy);
        nb(8'hFF, 1'($urandom)); nb(8'h00, 1'($urandom));
        nb(8'h00, 1'($urandom)); nb(xy, 1'($urandom));
    endtask

    // Scoreboard monitor: pop and compare each emitted pixel.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fmt_sel != 2'd2 && (sav_stb || eav_stb)) stray++;
            if (pix_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 R4 unexpected pixel", {8'h0, y_o, cb_o, cr_o}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk({y_o, cb_o, cr_o} == e, "R1 R3 R6 R7 pixel",
                        {8'h0, y_o, cb_o, cr_o}, {8'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk({y_o, cb_o, cr_o, pix_vld, sav_stb, eav_stb, field_o, vblank_o} == '0,
            "R11 reset", {y_o, cb_o, cr_o}, 0);
        rst_n = 1'b1;

        // Parallel packing
        fmt_sel = 2'd0;
        ws(8'h00, 8'h00, 1'b0);
        expect_grp(8'd40, 8'd5, 8'd250, 8'd240);
        ws(8'd5, 8'd40, 1'b1); ws(8'd240, 8'd250, 1'b1);
        expect_grp(8'd128, 8'd16, 8'd0, 8'd15);
        ws(8'd16, 8'd128, 1'b1); ws(8'd15, 8'd0, 1'b1);
        expect_grp(8'd255, 8'd235, 8'd16, 8'd255);
        ws(8'd235, 8'd255, 1'b1); ws(8'd255, 8'd16, 1'b1);
        // R4: partial group cut by act_in
        ws(8'd100, 8'd1, 1'b1); ws(8'd50, 8'd50, 1'b0);
        expect_grp(8'd70, 8'd60, 8'd71, 8'd61);
        ws(8'd60, 8'd70, 1'b1); ws(8'd61, 8'd71, 1'b1);
        ws(8'h00, 8'h00, 1'b0); ws(8'h00, 8'h00, 1'b0);

        // Byte-multiplexed packing
        fmt_sel = 2'd1;
        nb(8'h00, 1'b0); nb(8'h00, 1'b0);
        expect_grp(8'h80, 8'h0A, 8'hFF, 8'hEB);
        nb(8'h80, 1'b1); nb(8'h0A, 1'b1); nb(8'hFF, 1'b1); nb(8'hEB, 1'b1);
        chk(pix_vld && y_o == 8'd16, "R5 first pixel latency", {pix_vld, y_o}, {1'b1, 8'd16});
        nb(8'h00, 1'b0);
        chk(pix_vld && y_o == 8'hEB && cb_o == 8'h80 && cr_o == 8'hFF, "R5 second pixel",
            {pix_vld, y_o, cb_o, cr_o}, {1'b1, 8'hEB, 8'h80, 8'hFF});
        nb(8'h00, 1'b0);
        chk(!pix_vld, "R5 one strobe per luma", pix_vld, 0);
        // R4: restart after act_in low
        nb(8'h11, 1'b1); nb(8'h22, 1'b1); nb(8'h00, 1'b0);
        expect_grp(8'h30, 8'h40, 8'h50, 8'h60);
        nb(8'h30, 1'b1); nb(8'h40, 1'b1); nb(8'h50, 1'b1); nb(8'h60, 1'b1);
        nb(8'h00, 1'b0); nb(8'h00, 1'b0);
        // R12: reference-like bytes are data here
        expect_grp(8'hFF, 8'h00, 8'h00, 8'h80);
        nb(8'hFF, 1'b1); nb(8'h00, 1'b1); nb(8'h00, 1'b1); nb(8'h80, 1'b1);
        nb(8'h00, 1'b0); nb(8'h00, 1'b0); nb(8'h00, 1'b0);

        // Embedded-timing packing
        fmt_sel = 2'd2;
        nb(8'h10, 1'b1); nb(8'h10, 1'b0); nb(8'h10, 1'b1);
        trs(8'hC0);
        chk(sav_stb && !eav_stb, "R8 start strobe", {sav_stb, eav_stb}, 2'b10);
        chk(field_o && !vblank_o, "R8 flags", {field_o, vblank_o}, 2'b10);
        expect_grp(8'h80, 8'h20, 8'h80, 8'h30);
        expect_grp(8'h90, 8'h40, 8'hA0, 8'h50);
        nb(8'h80, 1'b0); nb(8'h20, 1'b0); nb(8'h80, 1'b1); nb(8'h30, 1'b0);
        nb(8'h90, 1'b1); nb(8'h40, 1'b1); nb(8'hA0, 1'b0); nb(8'h50, 1'b1);
        nb(8'h11, 1'b1); nb(8'h22, 1'b1);
        trs(8'hD0);
        chk(eav_stb && !sav_stb, "R8 end strobe", {sav_stb, eav_stb}, 2'b01);
        // R9: ancillary and blanking bytes ignored
        nb(8'h00, 1'b1); nb(8'hFF, 1'b1); nb(8'hFF, 1'b1); nb(8'h41, 1'b1);
        nb(8'h05, 1'b1); nb(8'h02, 1'b1); nb(8'hAA, 1'b1); nb(8'hBB, 1'b1);
        nb(8'h10, 1'b1); nb(8'h80, 1'b1); nb(8'h10, 1'b1); nb(8'h80, 1'b1);
        trs(8'hA0);
        chk(sav_stb && vblank_o, "R8 blank start flags", {sav_stb, vblank_o}, 2'b11);
        nb(8'h80, 1'b1); nb(8'h50, 1'b1); nb(8'h80, 1'b1); nb(8'h50, 1'b1);
        trs(8'hB0);
        trs(8'h80);
        chk(sav_stb && !field_o && !vblank_o, "R8 field two start",
            {sav_stb, field_o, vblank_o}, 3'b100);
        // R10: partial group, then a fresh start code restarts at Cb
        nb(8'h70, 1'b0); nb(8'h71, 1'b1); nb(8'h72, 1'b0);
        trs(8'h80);
        expect_grp(8'h80, 8'h60, 8'h90, 8'h61);
        nb(8'h80, 1'b1); nb(8'h60, 1'b0); nb(8'h90, 1'b1); nb(8'h61, 1'b0);
        trs(8'h90);
        chk(eav_stb, "R10 closing end strobe", eav_stb, 1);
        nb(8'h10, 1'b1); nb(8'h10, 1'b1); nb(8'h10, 1'b1);

        chk(exp_q.size() == 0, "R5 all expected pixels seen", exp_q.size(), 0);
        chk(stray == 0, "R12 no strobes outside embedded mode", stray, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule